// File: doc/BRIEF.md
# Half-Word Packet Stream Transmitter

This block turns a packet stream from an internal source into a 16-bit framed packet bus. The source offers two bytes per cycle on a valid/ready handshake, marks the final word of each packet, says whether that word holds one byte or two, and asks for a CRC-32 per packet. The transmitter registers every beat onto the bus. It raises a frame line for the whole packet and flags the single-byte tail of an odd-length packet. When the packet asks for it, the transmitter appends the Ethernet CRC-32 and packs it into the same two-bytes-per-beat stream.

An error input from the source raises an error line from the beat it arrives on until the frame ends. After each packet the transmitter holds the bus idle for a minimum gap before it accepts the next one. Once the source has handed over the first word of a packet, it must keep `in_valid` high until the last word.

Top module: `pkt16_tx`

## Requirements
- R1: After reset `tx_data` and `tx_ctl` are all zero and `in_ready` is high.
- R2: Within each beat the low lane `tx_data[7:0]` carries the earlier byte of the packet and `tx_data[15:8]` carries the later one. Bytes leave in the order the source supplied them.
- R3: `tx_ctl[0]` (frame) is high on every beat of a packet, from the first byte to the last byte, including CRC bytes. It is never low between them, and each beat appears one cycle after its word is accepted.
- R4: When the packet plus any CRC has an odd byte count, the final beat carries its last byte on `tx_data[7:0]` alone and `tx_ctl[2]` is high on that beat. `tx_ctl[2]` is low on every other beat.
- R5: With `in_crc_en` low on the first word, exactly the payload bytes are sent and nothing is appended.
- R6: With `in_crc_en` high on the first word, the four bytes of the reflected CRC-32 are sent after the payload, least significant byte first. The CRC uses polynomial 0x04C11DB7, initial value 0xFFFFFFFF and a final inversion. Packing continues in the free high lane of an odd tail, so for the payload "123456789" the bus carries 0x26, 0x39, 0xF4, 0xCB after the ninth byte.
- R7: When `in_err` is high on an accepted word, `tx_ctl[1]` is high on that word's beat and on every later beat of the same frame, CRC beats included. It is low again on the next packet unless that packet raises it anew.
- R8: While frame is low, `tx_ctl[1]` and `tx_ctl[2]` are low. `in_err` with no accepted word has no effect.
- R9: At least 3 cycles (parameter `IFG_CYCLES`) with frame low separate two packets. A source that is always ready sees exactly that many, because `in_ready` stays low through the CRC beats and the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Transmitter accepts a word this cycle |
| in_data | input | 16 | Two packet bytes, earlier byte in [7:0] |
| in_last | input | 1 | Word is the last of its packet |
| in_odd | input | 1 | With in_last: only [7:0] holds a byte |
| in_crc_en | input | 1 | Append CRC-32 (taken from the first word) |
| in_err | input | 1 | Source error for the current word |
| tx_data | output | 16 | Packet data bus |
| tx_ctl | output | 3 | [0] frame, [1] error, [2] odd tail |

## Verification
The bench goes after lane order and odd tails. A swapped lane or a dropped tail byte shows up as a byte mismatch, and a misplaced tail flag makes the received length come out wrong. The CRC cases cover even and odd payloads and a known check string. A wrong seed, a missing inversion or bad packing after an odd tail all give wrong trailing bytes. Error tests place `in_err` on the first, middle and last word of a packet and also pulse it while the bus is idle. A design that drops the error before the CRC beats, or leaks it into the next frame or into idle cycles, is caught by this. The bench measures the gap between back-to-back packets, so a design that opens `in_ready` too early shows fewer idle cycles.

// File: rtl/pkt16_pkg.sv
// Shared types and CRC arithmetic for the half-word packet transmitter.
// Assumes byte-wide CRC updates in reflected bit order.
package pkt16_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int CRC_W  = 32;

    localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_FCS  = 2'd2
    } tx_state_t;

    // Fold one byte into a reflected CRC-32 register.
    function automatic logic [CRC_W-1:0] crc_fold_byte(
        input logic [CRC_W-1:0]  c_in,
        input logic [BYTE_W-1:0] b
    );
        logic [CRC_W-1:0] c;
        c = c_in ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int k = 0; k < BYTE_W; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pkt16_crc.sv
// Combinational CRC-32 step over one half-word: the low byte is always
// folded in, the high byte only when hi_en is set. Assumes the caller
// supplies the running (non-inverted) CRC register.
module pkt16_crc
    import pkt16_pkg::*;
(
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [WORD_W-1:0] word,
    input  logic              hi_en,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] after_lo;

    // Fold the low lane, then optionally the high lane.
    always_comb begin
        after_lo = crc_fold_byte(crc_in, word[BYTE_W-1:0]);
        crc_out  = hi_en ? crc_fold_byte(after_lo, word[WORD_W-1:BYTE_W]) : after_lo;
    end

endmodule

// File: rtl/pkt16_fcs_mux.sv
// Selects the half-word of the final CRC that goes out on a CRC beat.
// Assumes the first CRC byte already left in the high lane of an odd tail
// when odd is set; beat 1 is the last CRC beat.
module pkt16_fcs_mux
    import pkt16_pkg::*;
(
    input  logic [CRC_W-1:0]  fcs,
    input  logic              odd,
    input  logic              beat,
    output logic [WORD_W-1:0] word,
    output logic              half
);

    // Map the remaining CRC bytes onto the two lanes, LSB first.
    always_comb begin
        unique case ({odd, beat})
            2'b00:   word = fcs[15:0];
            2'b01:   word = fcs[31:16];
            2'b10:   word = fcs[23:8];
            default: word = {{BYTE_W{1'b0}}, fcs[31:24]};
        endcase
        half = odd & beat;
    end

endmodule

// File: rtl/pkt16_gap.sv
// Inter-packet gap counter: load starts a countdown of IFG_CYCLES, and
// open is high once it has reached zero. Assumes load only at a frame end.
module pkt16_gap #(
    parameter int IFG_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic open
);

    localparam int CW = $clog2(IFG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(IFG_CYCLES);

    logic [CW-1:0] cnt;

    // Count down the idle cycles after each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= LOAD_VAL;
        else if (cnt != '0)    cnt <= cnt - CW'(1);
    end

    assign open = (cnt == '0);

    // A new frame end can only come once the previous gap has run out.
    assert_no_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> cnt == '0);

endmodule

// File: rtl/pkt16_tx.sv
// Half-word packet transmitter. Accepts two bytes per cycle from a source
// with valid/ready, registers each beat onto a 16-bit bus with frame,
// error and odd-tail controls, optionally appends CRC-32, and enforces an
// idle gap between packets. Assumes the source keeps in_valid high from
// the first to the last word of a packet.
module pkt16_tx
    import pkt16_pkg::*;
#(
    parameter int IFG_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_odd,
    input  logic              in_crc_en,
    input  logic              in_err,
    output logic [WORD_W-1:0] tx_data,
    output logic [2:0]        tx_ctl
);

    tx_state_t         state;
    logic [CRC_W-1:0]  crc_q, fcs_q;
    logic              crc_en_q, odd_q, beat_q, err_q;
    logic              gap_open, gap_load, accept, hi_en, crc_en_eff, err_now;
    logic [CRC_W-1:0]  crc_base, crc_nxt, fcs_now;
    logic [WORD_W-1:0] fcs_word;
    logic              fcs_half;

    // Handshake and per-word decode.
    always_comb begin
        in_ready   = ((state == ST_IDLE) && gap_open) || (state == ST_DATA);
        accept     = in_valid && in_ready;
        hi_en      = !(in_last && in_odd);
        crc_en_eff = (state == ST_IDLE) ? in_crc_en : crc_en_q;
        crc_base   = (state == ST_IDLE) ? CRC_SEED : crc_q;
        err_now    = err_q || in_err;
        fcs_now    = ~crc_nxt;
        gap_load   = (accept && in_last && !crc_en_eff) ||
                     ((state == ST_FCS) && beat_q);
    end

    pkt16_crc u_crc (
        .crc_in  (crc_base),
        .word    (in_data),
        .hi_en   (hi_en),
        .crc_out (crc_nxt)
    );

    pkt16_fcs_mux u_fcs_mux (
        .fcs  (fcs_q),
        .odd  (odd_q),
        .beat (beat_q),
        .word (fcs_word),
        .half (fcs_half)
    );

    pkt16_gap #(.IFG_CYCLES(IFG_CYCLES)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .open  (gap_open)
    );

    // Sequencer and output beat register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            crc_q    <= CRC_SEED;
            fcs_q    <= '0;
            crc_en_q <= 1'b0;
            odd_q    <= 1'b0;
            beat_q   <= 1'b0;
            err_q    <= 1'b0;
            tx_data  <= '0;
            tx_ctl   <= '0;
        end else begin
            tx_data <= '0;
            tx_ctl  <= '0;
            if (accept) begin
                crc_q    <= crc_nxt;
                crc_en_q <= crc_en_eff;
                err_q    <= err_now;
                tx_ctl[0] <= 1'b1;
                tx_ctl[1] <= err_now;
                tx_data[BYTE_W-1:0] <= in_data[BYTE_W-1:0];
                if (hi_en)           tx_data[WORD_W-1:BYTE_W] <= in_data[WORD_W-1:BYTE_W];
                else if (crc_en_eff) tx_data[WORD_W-1:BYTE_W] <= fcs_now[BYTE_W-1:0];
                if (!in_last) begin
                    state <= ST_DATA;
                end else if (crc_en_eff) begin
                    state  <= ST_FCS;
                    fcs_q  <= fcs_now;
                    odd_q  <= !hi_en;
                    beat_q <= 1'b0;
                end else begin
                    state     <= ST_IDLE;
                    err_q     <= 1'b0;
                    tx_ctl[2] <= !hi_en;
                end
            end else if (state == ST_FCS) begin
                tx_data   <= fcs_word;
                tx_ctl[0] <= 1'b1;
                tx_ctl[1] <= err_q;
                tx_ctl[2] <= fcs_half;
                beat_q    <= 1'b1;
                if (beat_q) begin
                    state <= ST_IDLE;
                    err_q <= 1'b0;
                end
            end
        end
    end

    // Source must not gap inside a packet (frame continuity).
    assert_src_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> in_valid);

    // Error and odd-tail lines stay quiet outside a frame.
    assert_ctl_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ctl[0] |-> (tx_ctl[2:1] == 2'b00));

    // Once raised, the error holds while the frame continues.
    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ctl[1] |=> (!tx_ctl[0] || tx_ctl[1]));

    // The odd-tail beat is always the final beat of its frame.
    assert_odd_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ctl[2] |=> !tx_ctl[0]);

    // No word is taken in the cycle right after a frame ends.
    assert_gap_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ctl[0]) |-> !in_ready);

endmodule

// File: tb/pkt16_tx_tb.sv
`timescale 1ns/1ps
module pkt16_tx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0, in_odd = 1'b0;
    logic        in_crc_en = 1'b0, in_err = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic [15:0] tx_data;
    logic [2:0]  tx_ctl;

    always #4 clk = ~clk;   // 125 MHz

    pkt16_tx u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_odd(in_odd),
        .in_crc_en(in_crc_en), .in_err(in_err), .tx_data(tx_data), .tx_ctl(tx_ctl)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Stimulus table: payload length, CRC request, error word (-1 none).
    localparam int NP = 8;
    localparam int T_LEN [NP] = '{1, 2, 7, 8, 5, 6, 3, 10};
    localparam bit T_CRC [NP] = '{0, 0, 1, 1, 0, 1, 1, 0};
    localparam int T_ERR [NP] = '{-1, -1, -1, -1, 1, 0, 1, -1};

    // Output monitor.
    logic [7:0] rxb [64];
    int  nb = 0, beat = 0, frames = 0, idle_cnt = 1000, m_idle = 0;
    int  m_err_first = -1;
    bit  inpkt = 0, m_err_drop = 0, m_early2 = 0, m_last2 = 0, m_badidle = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_ctl[0]) begin
                if (!inpkt) begin
                    inpkt = 1; nb = 0; beat = 0; m_err_first = -1;
                    m_err_drop = 0; m_early2 = 0; m_last2 = 0; m_idle = idle_cnt;
                end
                if (m_last2) m_early2 = 1;
                m_last2 = tx_ctl[2];
                if (tx_ctl[1] && m_err_first < 0) m_err_first = beat;
                if (!tx_ctl[1] && m_err_first >= 0) m_err_drop = 1;
                rxb[nb] = tx_data[7:0]; nb++;
                if (!tx_ctl[2]) begin rxb[nb] = tx_data[15:8]; nb++; end
                beat++;
            end else begin
                if (tx_ctl[2:1] != 2'b00) m_badidle = 1;
                if (inpkt) begin inpkt = 0; frames++; idle_cnt = 1; end
                else idle_cnt++;
            end
        end
    end

    function automatic logic [31:0] ref_crc(input logic [7:0] b [64], input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {24'd0, b[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    logic [7:0] pay [64];
    logic [7:0] exp_b [64];

    // Drive one packet from pay[], then compare the received frame.
    task automatic run_pkt(input int len, input bit crc, input int errw,
                           input bit chk_gap, input string tag);
        int words = (len + 1) / 2;
        int elen  = len + (crc ? 4 : 0);
        int prev  = frames;
        logic [31:0] c;
        bit same = 1;
        for (int i = 0; i < len; i++) exp_b[i] = pay[i];
        if (crc) begin
            c = ref_crc(pay, len);
            for (int i = 0; i < 4; i++) exp_b[len+i] = c[8*i +: 8];
        end
        for (int w = 0; w < words; w++) begin
            @(negedge clk);
            in_valid  = 1;
            in_data   = {(2*w+1 < len) ? pay[2*w+1] : 8'h00, pay[2*w]};
            in_last   = (w == words - 1);
            in_odd    = (w == words - 1) && len[0];
            in_crc_en = crc;
            in_err    = (w == errw);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        in_valid = 0; in_last = 0; in_odd = 0; in_err = 0; in_data = '0;
        wait (frames > prev);
        check(nb == elen, {tag, " R5 R6 byte count"}, nb, elen);
        for (int i = 0; i < elen && i < nb; i++) if (rxb[i] !== exp_b[i]) same = 0;
        check(same, {tag, " R2 R6 byte order/content"}, same, 1);
        check(m_last2 == elen[0] && !m_early2, {tag, " R4 odd tail flag"}, m_last2, elen[0]);
        check(m_err_first == errw && !m_err_drop, {tag, " R7 error line"}, m_err_first, errw);
        check(!m_badidle, {tag, " R8 idle controls"}, m_badidle, 0);
        if (chk_gap) check(m_idle == 3, {tag, " R9 idle gap"}, m_idle, 3);
        else         check(m_idle >= 3, {tag, " R9 idle gap min"}, m_idle, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(tx_data == 16'h0 && tx_ctl == 3'b000, "R1 reset outputs", {tx_ctl, tx_data}, 0);
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

        // Table walk: R2..R9 over lengths, CRC and error placements.
        for (int p = 0; p < NP; p++) begin
            for (int i = 0; i < T_LEN[p]; i++) pay[i] = 8'((p * 37 + i * 11 + 5) & 255);
            run_pkt(T_LEN[p], T_CRC[p], T_ERR[p], p > 0, $sformatf("tbl%0d", p));
        end

        // Directed R6: known check string, odd length.
        for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
        run_pkt(9, 1'b1, -1, 1'b1, "check-string");
        check({rxb[12], rxb[11], rxb[10], rxb[9]} == 32'hCBF4_3926, "R6 known CRC bytes",
              {rxb[12], rxb[11], rxb[10], rxb[9]}, 32'hCBF4_3926);

        // Directed R8: error pulse with nothing accepted is ignored.
        repeat (4) begin @(negedge clk); in_err = 1; end
        @(negedge clk); in_err = 0;
        check(tx_ctl == 3'b000, "R8 idle error ignored", tx_ctl, 0);
        for (int i = 0; i < 4; i++) pay[i] = 8'hA0 + 8'(i);
        run_pkt(4, 1'b0, -1, 1'b0, "post-idle-err");

        // Directed R7: error on the last word of a CRC packet carries into CRC beats.
        for (int i = 0; i < 4; i++) pay[i] = 8'h50 + 8'(i);
        run_pkt(4, 1'b1, 1, 1'b0, "err-last");
        check(beat == 4, "R3 frame beats incl CRC", beat, 4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R3 actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule